// File: doc/BRIEF.md
# Shadow RAM with Store and Recall

This block is a synchronous model of a small nonvolatile static memory. A working array of 64 four-bit words serves an ordinary single-port host interface: chip select, write enable, a 6-bit address, write data and registered read data with a validity flag. Beside it sits a second array of the same shape that stands for the nonvolatile cells. The host cannot reach this second array directly.

Two active-low request inputs move data between the arrays. A falling edge on the recall request fills the working array from the backing array. A falling edge on the store request saves the working array into the backing array. A sequencer runs each copy one word per clock and raises a busy flag while it runs. While busy is high the host port is locked out. Reset clears the working array and the sequencer, but the backing array keeps its contents. A recall after reset therefore brings back the last stored image.

Top module: `nv_shadow_mem`

## Requirements
- R1: With csN low, weN high and busy low at a clock edge, rdData holds the word stored at addr and rdValid is 1 from that edge until the next one. With csN low, weN low and busy low, wrData is written to the word at addr. Addresses 0 to 63 each hold 4 bits.
- R2: While csN is high: writes have no effect, rdValid is 0 and rdData is 0 (the high-impedance state) from the next edge, and a falling edge on storeN or recallN starts no copy.
- R3: While storeN and recallN both stay high, busy stays 0 and the block acts as a plain static RAM.
- R4: A recall request is a 1 to 0 change of recallN between two consecutive clock samples, taken while csN is low and busy is low. It copies every backing word into the working word at the same address.
- R5: A store request is the same change on storeN under the same conditions. It copies every working word into the backing word at the same address.
- R6: A request held low after its falling edge does not start another copy. Only a new falling edge can.
- R7: busy rises at the clock edge that samples the request. It stays 1 for exactly 64 cycles, in which addresses 0 through 63 are copied in ascending order, and falls at the next edge.
- R8: When storeN and recallN fall in the same sample, only the recall is performed. The backing array is left unchanged.
- R9: While busy is 1, host writes are ignored, rdValid stays 0 with rdData 0, and any store or recall edge is dropped. A dropped request does not run once busy falls.
- R10: Reset (rstN low) clears every working word to 0, clears busy, rdValid and rdData, and leaves the backing array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low; high means standby |
| weN | input | 1 | Write enable, active low; high means read |
| addr | input | 6 | Word address |
| wrData | input | 4 | Write data |
| rdData | output | 4 | Registered read data, 0 when not valid |
| rdValid | output | 1 | Output enable flag; 0 stands for the high-impedance state |
| storeN | input | 1 | Store request, active low, falling-edge started |
| recallN | input | 1 | Recall request, active low, falling-edge started |
| busy | output | 1 | High while a whole-array copy runs |

## Verification
The copy function is tried with two complementary word patterns, so a word copied from the wrong side, from the wrong address, or not copied at all reads back as a different value. A store, then an overwrite of the working array, then a recall separates a real save from stale working data. The same sequence with a reset in between separates a kept backing image from a cleared one. A simultaneous store and recall with different data on the two sides shows which direction won. A request held low, a request given in standby and host traffic given mid-copy (at an address the copy has already passed) each test the conditions that must not start a copy or change memory.

// File: rtl/nv_shadow_pkg.sv
package nv_shadow_pkg;

  // Strobes from the control to the datapath, one per cycle.
  typedef struct packed {
    logic hostWrite;
    logic hostRead;
    logic copyToRam;
    logic copyToNv;
  } memStrobe_t;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_STORE  = 2'd1,
    MODE_RECALL = 2'd2
  } copyMode_t;

endpackage

// File: rtl/nv_shadow_ctrl.sv
module nv_shadow_ctrl
  import nv_shadow_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              storeN,
  input  logic              recallN,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] copyPtr,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] LAST_PTR = {ADDR_W{1'b1}};

  copyMode_t mode;
  logic      prevStoreN;
  logic      prevRecallN;
  logic      storeFall;
  logic      recallFall;
  logic      accept;

  assign storeFall  = prevStoreN & ~storeN;
  assign recallFall = prevRecallN & ~recallN;
  assign accept     = ~csN & (mode == MODE_IDLE);
  assign busy       = (mode != MODE_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode        <= MODE_IDLE;
      copyPtr     <= '0;
      prevStoreN  <= 1'b1;
      prevRecallN <= 1'b1;
    end else begin
      prevStoreN  <= storeN;
      prevRecallN <= recallN;
      if (mode == MODE_IDLE) begin
        copyPtr <= '0;
        if (accept && recallFall) begin
          mode <= MODE_RECALL;
        end else if (accept && storeFall) begin
          mode <= MODE_STORE;
        end
      end else begin
        copyPtr <= copyPtr + 1'b1;
        if (copyPtr == LAST_PTR) begin
          mode <= MODE_IDLE;
        end
      end
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.hostWrite = ~csN & ~weN & ~busy;
    strobe.hostRead  = ~csN & weN & ~busy;
    strobe.copyToRam = (mode == MODE_RECALL);
    strobe.copyToNv  = (mode == MODE_STORE);
  end

endmodule

// File: rtl/nv_shadow_datapath.sv
module nv_shadow_datapath
  import nv_shadow_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] copyPtr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] workMem [DEPTH];
  logic [DATA_W-1:0] nvMem   [DEPTH];

  // Working array: cleared by reset, written by recall or host.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        workMem[i] <= '0;
      end
    end else if (strobe.copyToRam) begin
      workMem[copyPtr] <= nvMem[copyPtr];
    end else if (strobe.hostWrite) begin
      workMem[addr] <= wrData;
    end
  end

  // Backing array: no reset, written only by a store.
  always_ff @(posedge clk) begin
    if (strobe.copyToNv) begin
      nvMem[copyPtr] <= workMem[copyPtr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (strobe.hostRead) begin
      rdData  <= workMem[addr];
      rdValid <= 1'b1;
    end else begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/nv_shadow_mem.sv
module nv_shadow_mem
  import nv_shadow_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              storeN,
  input  logic              recallN,
  output logic              busy
);

  memStrobe_t        strobe;
  logic [ADDR_W-1:0] copyPtr;

  nv_shadow_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .weN     (weN),
    .storeN  (storeN),
    .recallN (recallN),
    .strobe  (strobe),
    .copyPtr (copyPtr),
    .busy    (busy)
  );

  nv_shadow_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .copyPtr (copyPtr),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/nv_shadow_chk.sv
module nv_shadow_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              weN,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              storeN,
  input logic              recallN,
  input logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 2;

  logic [CW-1:0] runLen;
  logic          seenStoreN;
  logic          seenRecallN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen      <= '0;
      seenStoreN  <= 1'b1;
      seenRecallN <= 1'b1;
    end else begin
      runLen      <= busy ? runLen + 1'b1 : '0;
      seenStoreN  <= storeN;
      seenRecallN <= recallN;
    end
  end

  p_read_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && !busy) |=> rdValid);

  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!rdValid && rdData == '0));

  p_standby_no_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !busy) |=> !busy);

  p_recall_starts_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !busy && seenRecallN && !recallN) |=> busy);

  p_edge_only_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(seenStoreN && !storeN) && !(seenRecallN && !recallN)) |=> !busy);

  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen < CW'(DEPTH)));

  p_busy_length_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == CW'(DEPTH)));

  p_busy_no_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !rdValid);

endmodule

bind nv_shadow_mem nv_shadow_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .weN     (weN),
  .rdData  (rdData),
  .rdValid (rdValid),
  .storeN  (storeN),
  .recallN (recallN),
  .busy    (busy)
);

// File: tb/test_nv_shadow_mem.sv
`timescale 1ns/1ps
module test_nv_shadow_mem;

  logic       clk = 1'b0;
  logic       rstN;
  logic       csN, weN, storeN, recallN;
  logic [5:0] addr;
  logic [3:0] wrData;
  logic [3:0] rdData;
  logic       rdValid;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       valid;
    logic [3:0] data;
    string      tag;
  } sbItem_t;

  sbItem_t sb[$];

  always #2.5 clk = ~clk;

  nv_shadow_mem i_nv_shadow_mem (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .storeN(storeN), .recallN(recallN), .busy(busy)
  );

  function automatic logic [3:0] patA(int i);
    return 4'((i * 5 + 3) % 16);
  endfunction

  function automatic logic [3:0] patB(int i);
    return ~patA(i);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read result one step after its edge.
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      sbItem_t it;
      it = sb.pop_front();
      check({it.tag, " valid"}, 8'(rdValid), 8'(it.valid));
      check({it.tag, " data"}, 8'(rdData), 8'(it.data));
    end
  end

  task automatic drive(logic c, logic w, int a, logic [3:0] d, logic s, logic r);
    @(negedge clk);
    csN = c; weN = w; addr = 6'(a); wrData = d; storeN = s; recallN = r;
  endtask

  task automatic hostWrite(int a, logic [3:0] d);
    drive(1'b0, 1'b0, a, d, 1'b1, 1'b1);
  endtask

  task automatic hostRead(int a, logic v, logic [3:0] d, string tag);
    sbItem_t it;
    drive(1'b0, 1'b1, a, 4'h0, 1'b1, 1'b1);
    it.valid = v; it.data = d; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic fillA();
    for (int i = 0; i < 64; i++) hostWrite(i, patA(i));
  endtask

  task automatic fillB();
    for (int i = 0; i < 64; i++) hostWrite(i, patB(i));
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 0, 4'h0, 1'b1, 1'b1);
  endtask

  // Pulls request lines low in one cycle with csN low; optionally releases.
  task automatic startReq(logic s, logic r, bit rel);
    drive(1'b0, 1'b1, 0, 4'h0, s, r);
    @(negedge clk);
    csN = 1'b1;
    if (rel) begin storeN = 1'b1; recallN = 1'b1; end
  endtask

  task automatic busyRun(string tag);
    int n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
    check(tag, 8'(n), 8'd64);
  endtask

  initial begin
    rstN = 1'b0; csN = 1'b1; weN = 1'b1; storeN = 1'b1; recallN = 1'b1;
    addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    @(negedge clk);
    check("R10 reset rdValid", 8'(rdValid), 8'd0);
    check("R10 reset rdData", 8'(rdData), 8'd0);
    check("R10 reset busy", 8'(busy), 8'd0);
    hostRead(5, 1'b1, 4'h0, "R10 working word zero after reset");

    // R1 / R3: plain RAM
    fillA();
    @(negedge clk);
    check("R3 busy stays low", 8'(busy), 8'd0);
    hostRead(0, 1'b1, patA(0), "R1 read addr 0");
    hostRead(63, 1'b1, patA(63), "R1 read addr 63");
    hostRead(1, 1'b1, patA(1), "R1 read addr 1");
    hostRead(17, 1'b1, patA(17), "R1 read addr 17");
    hostWrite(17, 4'h0);
    hostRead(17, 1'b1, 4'h0, "R1 overwrite addr 17");
    hostWrite(17, patA(17));

    // R2: standby
    drive(1'b1, 1'b0, 3, ~patA(3), 1'b1, 1'b1);
    begin
      sbItem_t it;
      drive(1'b1, 1'b1, 3, 4'h0, 1'b1, 1'b1);
      it.valid = 1'b0; it.data = 4'h0; it.tag = "R2 standby read disabled";
      sb.push_back(it);
    end
    hostRead(3, 1'b1, patA(3), "R2 standby write ignored");
    drive(1'b1, 1'b1, 0, 4'h0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 0, 4'h0, 1'b1, 1'b0);
    idle();
    check("R2 standby store/recall ignored", 8'(busy), 8'd0);

    // R5 / R7: store patA
    startReq(1'b0, 1'b1, 1'b1);
    busyRun("R7 store busy length");
    fillB();
    startReq(1'b1, 1'b0, 1'b1);
    busyRun("R7 recall busy length");
    hostRead(0, 1'b1, patA(0), "R4 recall addr 0");
    hostRead(33, 1'b1, patA(33), "R4/R5 recall addr 33");
    hostRead(63, 1'b1, patA(63), "R4/R5 recall addr 63");

    // R8: simultaneous, working=patB, backing=patA
    fillB();
    startReq(1'b0, 1'b0, 1'b1);
    busyRun("R8 busy length");
    hostRead(10, 1'b1, patA(10), "R8 recall won");
    hostRead(50, 1'b1, patA(50), "R8 recall won addr 50");
    fillB();
    startReq(1'b1, 1'b0, 1'b1);
    busyRun("R8 second recall length");
    hostRead(10, 1'b1, patA(10), "R8 backing unchanged");

    // R6: store with request held low, working=patB
    fillB();
    startReq(1'b0, 1'b1, 1'b0);
    busyRun("R6 held store length");
    csN = 1'b0;
    weN = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 19) check("R6 held low no restart", 8'(busy), 8'd0);
    end
    storeN = 1'b1;
    fillA();
    startReq(1'b1, 1'b0, 1'b1);
    busyRun("R5 recall after store");
    hostRead(7, 1'b1, patB(7), "R5 stored image restored");

    // R9: lockout during recall, working=patA, backing=patB
    fillA();
    startReq(1'b1, 1'b0, 1'b1);
    repeat (8) idle();
    hostWrite(2, 4'h9);
    hostRead(40, 1'b0, 4'h0, "R9 read blocked while busy");
    drive(1'b0, 1'b1, 0, 4'h0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 0, 4'h0, 1'b1, 1'b1);
    begin
      int n = 0;
      while (busy && n < 200) begin n++; @(negedge clk); end
    end
    for (int k = 0; k < 5; k++) idle();
    check("R9 dropped request not run", 8'(busy), 8'd0);
    hostRead(2, 1'b1, patB(2), "R9 write ignored while busy");

    // R10: reset keeps backing (patB)
    fillA();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    hostRead(7, 1'b1, 4'h0, "R10 working cleared");
    startReq(1'b1, 1'b0, 1'b1);
    busyRun("R10 recall length");
    hostRead(7, 1'b1, patB(7), "R10 backing kept");
    hostRead(60, 1'b1, patB(60), "R10 backing kept addr 60");

    idle();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule